// File: doc/BRIEF.md
# Single-Shot Block Copy Engine with Local Byte Buffer

This block copies a run of bytes between host memory and a 4096-byte buffer held inside the block. The buffer is reached through a fixed window of device addresses starting at 0x40000. Software fills in four 64-bit registers through a simple register port: a source address, a destination address, a byte count and a command word. A command write with the run bit set arms the engine. The engine then waits a fixed number of cycles and checks that the local side of the transfer lies wholly inside the window. If it does, the engine moves the bytes one at a time over a byte-wide host memory request port. When the copy ends it clears the run bit and, if software asked for it, pulses a done-interrupt line.

The direction bit of the command chooses which register addresses host memory and which addresses the local window. Host addresses are ANDed with a DMA mask before they leave the block. When the local range is invalid, the engine moves nothing. It drops the run bit and sets a sticky error flag, which software reads in the command register.

Top module: `dma_engine`

## Requirements
- R1: After reset the source, destination, count and command registers all read 0. The block makes no host request, and the done-interrupt line is low.
- R2: The four registers sit at fixed offsets: source at 0x80, destination at 0x88, count at 0x90 and command at 0x98.
  - With `reg_size8`=1, an access moves all 64 bits.
  - With `reg_size8`=0, a write stores the low 32 bits zero-extended, and a read returns the low 32 bits with the upper half 0.
  - A read of any other offset returns all ones. A write to any other offset changes nothing.
- R3: A command write whose bit 0 (run) is 0 is ignored. The command register keeps its value and no transfer starts.
- R4: While command bit 0 reads 1, writes to the source, destination, count and command registers are all ignored.
- R5: With command bit 1 = 0 (host to local), byte i is read from host address (source + i) masked. It is stored at buffer offset destination − 0x40000 + i.
- R6: With command bit 1 = 1 (local to host), byte i is taken from buffer offset source − 0x40000 + i. It is written to host address (destination + i) masked.
- R7: Every host address driven on `mem_addr` is the computed address ANDed with the DMA mask. The default mask is 2^28 − 1, so the upper address bits are 0.
- R8: No host request is made earlier than START_DELAY cycles after the accepted command write.
- R9: The local address must be at least 0x40000, the local address plus the count must be at most 0x41000, and the count must be nonzero.
  - When these hold, the copy proceeds.
  - Otherwise the engine makes no host request, clears the run bit and sets command bit 31. Bit 31 stays set until reset.
- R10: After the last byte the run bit clears. `done_irq` pulses high for exactly one cycle if command bit 2 was set, and stays low otherwise.
- R11: Exactly one byte moves per cycle in which `mem_req` and `mem_ack` are both high. While `mem_ack` is low, the request and its address hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_size8 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Host byte request |
| mem_we | output | 1 | 1 = host write, 0 = host read |
| mem_addr | output | 64 | Masked host byte address |
| mem_wdata | output | 8 | Byte written to host |
| mem_ack | input | 1 | Host accepts the request this cycle |
| mem_rdata | input | 8 | Host read byte, valid with `mem_ack` |
| done_irq | output | 1 | One-cycle completion interrupt pulse |

## Verification
The bench builds the engine with START_DELAY set to 5 and keeps the defaults for the 4096-byte buffer, the 0x40000 window base and the 28-bit mask. A short delay lets it count the idle cycles before the first request. It also leaves time to issue locked-out writes while the run bit is still set.

With the default window and mask, the bench can hit the exact upper edge of the window, just as 0x41000 is reached and one byte beyond it. It can also place host addresses with high bits set, so the masking shows on `mem_addr`. An acknowledge pattern that toggles every cycle drives the stall path. A copy into the buffer followed by a copy back out brings the buffer contents to the ports.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned REG_W = 64;
  localparam logic [7:0] OFS_SRC = 8'h80;
  localparam logic [7:0] OFS_DST = 8'h88;
  localparam logic [7:0] OFS_CNT = 8'h90;
  localparam logic [7:0] OFS_CMD = 8'h98;
  localparam int unsigned CMD_RUN = 0;
  localparam int unsigned CMD_DIR = 1;
  localparam int unsigned CMD_IRQ = 2;
  localparam int unsigned CMD_ERR = 31;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_COPY} dma_state_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       addr,
  input  logic             size8,
  input  logic [REG_W-1:0] wdata,
  input  logic             xfer_done,
  input  logic             xfer_abort,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] src,
  output logic [REG_W-1:0] dst,
  output logic [REG_W-1:0] cnt,
  output logic             run,
  output logic             dir,
  output logic             irq_en,
  output logic             start
);
  logic [REG_W-1:0] cmd_q, cmd_d, src_d, dst_d, cnt_d, wval;
  logic             err_q, err_d, wr_ok;

  assign wval  = size8 ? wdata : {32'b0, wdata[31:0]};
  assign wr_ok = wr & ~run;
  assign start = wr_ok & (addr == OFS_CMD) & wval[CMD_RUN];

  always_comb begin
    src_d = src;
    dst_d = dst;
    cnt_d = cnt;
    cmd_d = cmd_q;
    err_d = err_q | xfer_abort;
    if (xfer_done | xfer_abort) cmd_d[CMD_RUN] = 1'b0;
    if (wr_ok) begin
      case (addr)
        OFS_SRC: src_d = wval;
        OFS_DST: dst_d = wval;
        OFS_CNT: cnt_d = wval;
        OFS_CMD: if (wval[CMD_RUN]) begin
                   cmd_d = wval;
                   cmd_d[CMD_ERR] = 1'b0;
                 end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src   <= '0;
      dst   <= '0;
      cnt   <= '0;
      cmd_q <= '0;
      err_q <= 1'b0;
    end else begin
      src   <= src_d;
      dst   <= dst_d;
      cnt   <= cnt_d;
      cmd_q <= cmd_d;
      err_q <= err_d;
    end
  end

  assign run    = cmd_q[CMD_RUN];
  assign dir    = cmd_q[CMD_DIR];
  assign irq_en = cmd_q[CMD_IRQ];

  logic [REG_W-1:0] rd_full;
  always_comb begin
    case (addr)
      OFS_SRC: rd_full = src;
      OFS_DST: rd_full = dst;
      OFS_CNT: rd_full = cnt;
      OFS_CMD: begin
                 rd_full = cmd_q;
                 rd_full[CMD_ERR] = err_q;
               end
      default: rd_full = '1;
    endcase
    rdata = size8 ? rd_full : {32'b0, rd_full[31:0]};
  end

  // R4: the operand registers do not move under a write while running
  a_r4_locked_while_run: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && run) |=> ($stable(src) && $stable(dst) && $stable(cnt)));

  // R3: a command write lacking the run bit never starts anything
  a_r3_cmd_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !run && addr == OFS_CMD && !wdata[CMD_RUN]) |=> !run);

  // R9: the error flag stays set until reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/dma_range_chk.sv
module dma_range_chk
  import dma_pkg::*;
#(
  parameter int unsigned      BUF_BYTES = 4096,
  parameter logic [REG_W-1:0] WIN_BASE  = 64'h40000,
  localparam int unsigned     IDX_W     = $clog2(BUF_BYTES)
) (
  input  logic [REG_W-1:0] loc_addr,
  input  logic [REG_W-1:0] len,
  output logic             ok,
  output logic [IDX_W-1:0] ofs
);
  logic [REG_W:0] end_sum, win_end, rel;

  assign end_sum = {1'b0, loc_addr} + {1'b0, len};
  assign win_end = {1'b0, WIN_BASE} + (REG_W+1)'(BUF_BYTES);
  assign rel     = {1'b0, loc_addr} - {1'b0, WIN_BASE};
  assign ok      = (len != '0) && (loc_addr >= WIN_BASE) && (end_sum <= win_end);
  assign ofs     = rel[IDX_W-1:0];
endmodule

// File: rtl/dma_lbuf.sv
module dma_lbuf #(
  parameter int unsigned  BUF_BYTES = 4096,
  localparam int unsigned IDX_W     = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] mem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dma_copy_fsm.sv
module dma_copy_fsm
  import dma_pkg::*;
#(
  parameter int unsigned      START_DELAY = 100,
  parameter int unsigned      BUF_BYTES   = 4096,
  parameter logic [REG_W-1:0] DMA_MASK    = 64'h0FFF_FFFF,
  localparam int unsigned     IDX_W       = $clog2(BUF_BYTES),
  localparam int unsigned     CNT_W       = $clog2(BUF_BYTES + 1),
  localparam int unsigned     DLY_W       = (START_DELAY > 0) ? $clog2(START_DELAY + 1) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic             irq_en,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] cnt,
  input  logic             range_ok,
  input  logic [IDX_W-1:0] loc_ofs,
  input  logic             mem_ack,
  input  logic [7:0]       mem_rdata,
  input  logic [7:0]       buf_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [REG_W-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_idx,
  output logic             xfer_done,
  output logic             xfer_abort,
  output logic             irq
);
  dma_state_e       st_q, st_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             irq_d, last, hs;
  logic [REG_W-1:0] host_base;

  assign host_base = dir ? dst : src;
  assign mem_req   = (st_q == ST_COPY);
  assign mem_we    = dir;
  assign mem_addr  = (host_base + REG_W'(idx_q)) & DMA_MASK;
  assign mem_wdata = buf_rdata;
  assign buf_idx   = loc_ofs + idx_q[IDX_W-1:0];
  assign hs        = mem_req & mem_ack;
  assign buf_we    = hs & ~dir;
  assign last      = (idx_q == cnt[CNT_W-1:0] - CNT_W'(1));

  always_comb begin
    st_d       = st_q;
    dly_d      = dly_q;
    idx_d      = idx_q;
    irq_d      = 1'b0;
    xfer_done  = 1'b0;
    xfer_abort = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
                 st_d  = ST_WAIT;
                 dly_d = DLY_W'(START_DELAY);
               end
      ST_WAIT: if (dly_q != '0) begin
                 dly_d = dly_q - DLY_W'(1);
               end else if (range_ok) begin
                 st_d  = ST_COPY;
                 idx_d = '0;
               end else begin
                 st_d       = ST_IDLE;
                 xfer_abort = 1'b1;
               end
      ST_COPY: if (hs) begin
                 idx_d = idx_q + CNT_W'(1);
                 if (last) begin
                   st_d      = ST_IDLE;
                   xfer_done = 1'b1;
                   irq_d     = irq_en;
                 end
               end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dly_q <= '0;
      idx_q <= '0;
      irq   <= 1'b0;
    end else begin
      st_q  <= st_d;
      dly_q <= dly_d;
      idx_q <= idx_d;
      irq   <= irq_d;
    end
  end

  // R11: a stalled request keeps its address
  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R9: never touch host memory with an out-of-window local range
  a_r9_req_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> range_ok);

  // R7: masked host address
  a_r7_addr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr & ~DMA_MASK) == '0));

  // R10: the interrupt is a single-cycle pulse
  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned      START_DELAY = 100,
  parameter int unsigned      BUF_BYTES   = 4096,
  parameter logic [REG_W-1:0] WIN_BASE    = 64'h40000,
  parameter int unsigned      MASK_BITS   = 28,
  localparam logic [REG_W-1:0] DMA_MASK   = (REG_W'(1) << MASK_BITS) - REG_W'(1),
  localparam int unsigned     IDX_W       = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic             reg_size8,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [REG_W-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_ack,
  input  logic [7:0]       mem_rdata,
  output logic             done_irq
);
  logic [REG_W-1:0] src, dst, cnt;
  logic             run, dir, irq_en, start, xfer_done, xfer_abort, range_ok, buf_we;
  logic [IDX_W-1:0] loc_ofs, buf_idx;
  logic [7:0]       buf_rdata;

  dma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .size8(reg_size8),
    .wdata(reg_wdata), .xfer_done(xfer_done), .xfer_abort(xfer_abort),
    .rdata(reg_rdata), .src(src), .dst(dst), .cnt(cnt), .run(run), .dir(dir),
    .irq_en(irq_en), .start(start)
  );

  dma_range_chk #(.BUF_BYTES(BUF_BYTES), .WIN_BASE(WIN_BASE)) u_range (
    .loc_addr(dir ? src : dst), .len(cnt), .ok(range_ok), .ofs(loc_ofs)
  );

  dma_lbuf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_idx), .wdata(mem_rdata),
    .raddr(buf_idx), .rdata(buf_rdata)
  );

  dma_copy_fsm #(.START_DELAY(START_DELAY), .BUF_BYTES(BUF_BYTES), .DMA_MASK(DMA_MASK)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .irq_en(irq_en),
    .src(src), .dst(dst), .cnt(cnt), .range_ok(range_ok), .loc_ofs(loc_ofs),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .buf_rdata(buf_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .buf_we(buf_we), .buf_idx(buf_idx), .xfer_done(xfer_done),
    .xfer_abort(xfer_abort), .irq(done_irq)
  );

  // R10: the completion pulse comes only once the run bit has dropped
  a_r10_irq_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !run);

  // R8: no host traffic unless a command is running
  a_r8_req_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> run);
endmodule

// File: tb/tb_dma_engine.sv
module tb_dma_engine;
  localparam int unsigned DLY = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic        reg_size8 = 1'b1;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        mem_req, mem_we, done_irq;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_ack;
  logic        stall_en = 1'b0;
  logic        ack_phase = 1'b0;

  int checks = 0;
  int errors = 0;
  int hs_cnt = 0;
  int irq_cnt = 0;
  logic [63:0] hs_log [64];
  logic [7:0]  hwr [4096];
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  dma_engine #(.START_DELAY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_size8(reg_size8), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done_irq(done_irq)
  );

  function automatic logic [7:0] hpat(input logic [63:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign mem_ack   = mem_req & (~stall_en | ack_phase);
  assign mem_rdata = hpat(mem_addr);

  always @(negedge clk) begin
    ack_phase <= ~ack_phase;
    if (done_irq) irq_cnt <= irq_cnt + 1;
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      hs_log[hs_cnt % 64] <= mem_addr;
      hs_cnt <= hs_cnt + 1;
      if (mem_we) hwr[mem_addr[11:0]] <= mem_wdata;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic s8);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_size8 = s8; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_size8 = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, input logic s8, output logic [63:0] v);
    @(negedge clk);
    reg_addr = a; reg_size8 = s8;
    #1 v = reg_rdata;
    reg_size8 = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // program and launch; returns idle cycles before first request, handshakes, irq pulses
  task automatic xfer(input logic [63:0] s, input logic [63:0] d, input logic [63:0] n,
                      input logic [63:0] cmd, output int pre, output int hs, output int irqs,
                      output int first_idx);
    int hs0, irq0;
    logic [63:0] v;
    wr(8'h80, s, 1'b1);
    wr(8'h88, d, 1'b1);
    wr(8'h90, n, 1'b1);
    hs0 = hs_cnt; irq0 = irq_cnt; first_idx = hs0 % 64;
    wr(8'h98, cmd, 1'b1);
    pre = 0;
    while (!mem_req && pre < 40) begin
      pre++;
      @(negedge clk);
    end
    for (int i = 0; i < 600; i++) begin
      rd(8'h98, 1'b1, v);
      if (!v[0]) break;
    end
    repeat (2) @(negedge clk);
    hs = hs_cnt - hs0; irqs = irq_cnt - irq0;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(8'h80, 1'b1, v); chk("R1 src reset", v, 64'h0);
    rd(8'h88, 1'b1, v); chk("R1 dst reset", v, 64'h0);
    rd(8'h90, 1'b1, v); chk("R1 cnt reset", v, 64'h0);
    rd(8'h98, 1'b1, v); chk("R1 cmd reset", v, 64'h0);
    chk("R1 no req", {63'b0, mem_req}, 64'h0);
    chk("R1 irq low", {63'b0, done_irq}, 64'h0);
  endtask

  task automatic t_regmap();
    logic [63:0] v;
    wr(8'h80, 64'h1122_3344_5566_7788, 1'b1);
    rd(8'h80, 1'b1, v); chk("R2 src 64", v, 64'h1122_3344_5566_7788);
    rd(8'h80, 1'b0, v); chk("R2 src 32 read", v, 64'h5566_7788);
    wr(8'h88, 64'hFFFF_FFFF_AABB_CCDD, 1'b0);
    rd(8'h88, 1'b1, v); chk("R2 dst 32 write", v, 64'hAABB_CCDD);
    wr(8'h90, 64'h0000_0000_0000_0123, 1'b1);
    rd(8'h90, 1'b1, v); chk("R2 cnt 64", v, 64'h123);
    rd(8'h00, 1'b1, v); chk("R2 unmapped read", v, '1);
    wr(8'h40, 64'h0, 1'b1);
    rd(8'h80, 1'b1, v); chk("R2 unmapped write", v, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_cmd_ignore();
    logic [63:0] v;
    int h0;
    h0 = hs_cnt;
    wr(8'h98, 64'h6, 1'b1);
    rd(8'h98, 1'b1, v); chk("R3 cmd unchanged", v, 64'h0);
    repeat (20) @(negedge clk);
    chk("R3 no transfer", 64'(hs_cnt - h0), 64'h0);
  endtask

  task automatic t_h2l();
    int pre, hs, irqs, fi;
    xfer(64'h200, 64'h40010, 64'd16, 64'h5, pre, hs, irqs, fi);
    chk("R8 start delay", 64'(pre >= int'(DLY)), 64'h1);
    chk("R11 handshakes", 64'(hs), 64'd16);
    chk("R5 first host addr", hs_log[fi], 64'h200);
    chk("R10 irq pulse once", 64'(irqs), 64'd1);
  endtask

  task automatic t_l2h();
    int pre, hs, irqs, fi;
    int bad = 0;
    xfer(64'h40010, 64'h600, 64'd16, 64'h3, pre, hs, irqs, fi);
    for (int i = 0; i < 16; i++)
      if (hwr[12'h600 + i] !== hpat(64'h200 + 64'(i))) bad++;
    chk("R6 bytes copied out", 64'(bad), 64'h0);
    chk("R6 first host addr", hs_log[fi], 64'h600);
    chk("R10 no irq when bit2 clear", 64'(irqs), 64'd0);
  endtask

  task automatic t_lock();
    logic [63:0] v;
    wr(8'h80, 64'h40000, 1'b1);
    wr(8'h88, 64'h700, 1'b1);
    wr(8'h90, 64'd4, 1'b1);
    wr(8'h98, 64'h3, 1'b1);
    wr(8'h80, 64'h999, 1'b1);
    wr(8'h90, 64'd9, 1'b1);
    wr(8'h98, 64'h5, 1'b1);
    rd(8'h80, 1'b1, v); chk("R4 src locked", v, 64'h40000);
    rd(8'h90, 1'b1, v); chk("R4 cnt locked", v, 64'd4);
    rd(8'h98, 1'b1, v); chk("R4 cmd locked", v, 64'h3);
    for (int i = 0; i < 100; i++) begin
      rd(8'h98, 1'b1, v);
      if (!v[0]) break;
    end
    chk("R4 run cleared after", v & 64'h1, 64'h0);
  endtask

  task automatic t_mask();
    int pre, hs, irqs, fi;
    xfer(64'hFFFF_0000_1000_0300, 64'h40000, 64'd4, 64'h1, pre, hs, irqs, fi);
    chk("R7 masked host addr", hs_log[fi], 64'h300);
    chk("R7 handshakes", 64'(hs), 64'd4);
  endtask

  task automatic t_edge_ok();
    int pre, hs, irqs, fi;
    logic [63:0] v;
    xfer(64'h10, 64'h40FFC, 64'd4, 64'h1, pre, hs, irqs, fi);
    chk("R9 top of window accepted", 64'(hs), 64'd4);
    rd(8'h98, 1'b1, v); chk("R9 no error at edge", v & 64'h8000_0000, 64'h0);
  endtask

  task automatic t_stall();
    int pre, hs, irqs, fi;
    int bad = 0;
    stall_en = 1'b1;
    xfer(64'h80, 64'h40100, 64'd8, 64'h1, pre, hs, irqs, fi);
    chk("R11 stalled in handshakes", 64'(hs), 64'd8);
    xfer(64'h40100, 64'hA00, 64'd8, 64'h3, pre, hs, irqs, fi);
    chk("R11 stalled out handshakes", 64'(hs), 64'd8);
    for (int i = 0; i < 8; i++)
      if (hwr[12'hA00 + i] !== hpat(64'h80 + 64'(i))) bad++;
    chk("R11 stalled data", 64'(bad), 64'h0);
    stall_en = 1'b0;
  endtask

  task automatic t_abort(input string tag, input logic [63:0] loc, input logic [63:0] n);
    int pre, hs, irqs, fi;
    logic [63:0] v;
    do_reset();
    xfer(64'h100, loc, n, 64'h5, pre, hs, irqs, fi);
    chk({"R9 no access ", tag}, 64'(hs), 64'h0);
    rd(8'h98, 1'b1, v);
    chk({"R9 run clear ", tag}, v & 64'h1, 64'h0);
    chk({"R9 err set ", tag}, v & 64'h8000_0000, 64'h8000_0000);
  endtask

  task automatic t_sticky();
    int pre, hs, irqs, fi;
    logic [63:0] v;
    xfer(64'h100, 64'h40000, 64'd2, 64'h1, pre, hs, irqs, fi);
    rd(8'h98, 1'b1, v); chk("R9 err sticky", v & 64'h8000_0000, 64'h8000_0000);
    do_reset();
    rd(8'h98, 1'b1, v); chk("R9 err cleared by reset", v, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_cmd_ignore();
    t_h2l();
    t_l2h();
    t_lock();
    t_mask();
    t_edge_ok();
    t_stall();
    t_abort("past end", 64'h40FFD, 64'd4);
    t_abort("zero count", 64'h40000, 64'd0);
    t_abort("below base", 64'h3FFFF, 64'd2);
    t_sticky();
    summary();
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule